// File: doc/BRIEF.md
# Time Slot Interchange Circuit Switch

This block switches byte-wide circuits between synchronous time-division links. Each of the `NUM_LINKS` input links delivers one byte per clock. A frame is exactly `NUM_SLOTS` consecutive cycles, and a shared frame pulse marks its first slot. A circuit is the byte at one fixed slot position in every frame. Nothing in the byte names its circuit: the position alone identifies it.

Every incoming frame is stored in an interchange memory in which each link and slot can be addressed on its own. In the following frame, each output link and output slot fetches a stored byte. A connection table indexed by the output link and output slot chooses that byte by naming a source link and a source slot. A single lookup therefore performs both the slot reordering and the routing across links. Each circuit receives exactly one byte per frame.

The table is written one entry at a time through a small write port, which stands in for call setup. New entries are held aside and only take effect at a frame boundary, so no output frame is ever switched with a partly updated map. All inputs must already be aligned to the common frame pulse.

Top module: `tsi_switch`

## Requirements
- R1: While `rstN` is low, every output lane reads all ones (0xFF) and `outFrameStart` is 0.
- R2: `outFrameStart` is 1 exactly in the cycle after a cycle with `frameStart` high. This marks output slot 0.
- R3: Slot k is the k-th cycle counting the `frameStart` cycle as slot 0. Output lane o is `outData[o*DATA_W +: DATA_W]`. If the active entry for (o, k) is valid, lane o in the cycle after input slot k of frame F+1 carries the byte that input link srcLink presented at slot srcSlot of frame F.
- R4: If the active entry for (o, k) is invalid, lane o carries the idle byte 0xFF in that output slot.
- R5: A table write takes effect at the first `frameStart` that comes strictly after the write cycle. A write in the same cycle as `frameStart` waits for the next `frameStart`. Until then, the rest of the current output frame uses the previous map.
- R6: One source slot may feed any number of output slots, on any output links, within the same frame.
- R7: After reset every table entry is invalid. All lanes stay idle before the first `frameStart` and throughout the first output frame after it, because no complete input frame has yet been stored.
- R8: A cycle with `cfgWe` high writes the entry addressed by (`cfgOutLink`, `cfgOutSlot`). The entry holds `cfgValid`, `cfgSrcLink` and `cfgSrcSlot`. Any entry can be rewritten any number of times, and the last write before a boundary is the one that applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle on every link |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | High in the cycle that carries slot 0 on all input links |
| inData | input | NUM_LINKS*DATA_W | Input link bytes; link l in bits [l*DATA_W +: DATA_W] |
| cfgWe | input | 1 | Connection table write strobe |
| cfgOutLink | input | LINK_W | Output link of the entry being written |
| cfgOutSlot | input | SLOT_W | Output slot of the entry being written |
| cfgValid | input | 1 | Entry carries a circuit (1) or idle (0) |
| cfgSrcLink | input | LINK_W | Source input link for the entry |
| cfgSrcSlot | input | SLOT_W | Source input slot for the entry |
| outData | output | NUM_LINKS*DATA_W | Output link bytes; lane o in bits [o*DATA_W +: DATA_W] |
| outFrameStart | output | 1 | High in the cycle that carries output slot 0 |

## Verification
The hardest case to reach is a map change at a frame edge. This covers a write that arrives in the same cycle as the frame pulse, and a write in the middle of a frame whose target slot has not yet been read out. Both must leave the map in use for the frame in progress unchanged. The bench feeds table writes from a queue that releases one entry per slot cycle, so the timing of each write relative to the pulse is chosen exactly. It then compares every output byte with a reference map that moves pending entries to the active map only at the boundary. Every input byte is a distinct arithmetic function of frame, link and slot, so a byte taken from the wrong bank, slot or frame shows up as a mismatch.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
  // strobes from the frame sequencer to the interchange datapath
  typedef struct packed {
    logic wrEn;    // store the current input slot
    logic wrBank;  // bank receiving the current frame
  } tsi_strobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
`timescale 1ns/1ps
module tsi_ctrl #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameStart,
  output tsi_pkg::tsi_strobe_t   strobe,
  output logic                   commit,
  output logic [SLOT_W-1:0]      curSlot
);
  logic [SLOT_W-1:0] slotCnt;
  logic bankReg, runReg;
  logic curBank, curRun;

  always_comb begin
    curSlot       = frameStart ? '0 : slotCnt;
    curBank       = frameStart ? ~bankReg : bankReg;
    curRun        = frameStart | runReg;
    strobe.wrEn   = curRun;
    strobe.wrBank = curBank;
    commit        = frameStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      bankReg <= 1'b0;
      runReg  <= 1'b0;
    end else begin
      slotCnt <= (curSlot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : curSlot + 1'b1;
      bankReg <= curBank;
      runReg  <= curRun;
    end
  end
endmodule

// File: rtl/tsi_conn_table.sv
`timescale 1ns/1ps
module tsi_conn_table #(
  parameter int NUM_LINKS = 2,
  parameter int NUM_SLOTS = 8,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ENT_W  = 1 + LINK_W + SLOT_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              commit,
  input  logic [SLOT_W-1:0]                 curSlot,
  input  logic                              cfgWe,
  input  logic [LINK_W-1:0]                 cfgOutLink,
  input  logic [SLOT_W-1:0]                 cfgOutSlot,
  input  logic                              cfgValid,
  input  logic [LINK_W-1:0]                 cfgSrcLink,
  input  logic [SLOT_W-1:0]                 cfgSrcSlot,
  output logic [NUM_LINKS-1:0]              lkValid,
  output logic [NUM_LINKS*LINK_W-1:0]       lkLink,
  output logic [NUM_LINKS*SLOT_W-1:0]       lkSlot,
  output logic [NUM_LINKS*NUM_SLOTS*ENT_W-1:0] activeTbl
);
  // pending map collects writes; active map drives switching
  logic [ENT_W-1:0] pendMem   [NUM_LINKS][NUM_SLOTS];
  logic [ENT_W-1:0] activeMem [NUM_LINKS][NUM_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINKS; l++) begin
        for (int k = 0; k < NUM_SLOTS; k++) begin
          pendMem[l][k]   <= '0;
          activeMem[l][k] <= '0;
        end
      end
    end else begin
      if (cfgWe) pendMem[cfgOutLink][cfgOutSlot] <= {cfgValid, cfgSrcLink, cfgSrcSlot};
      if (commit) activeMem <= pendMem;
    end
  end

  for (genvar o = 0; o < NUM_LINKS; o++) begin : g_look
    logic [ENT_W-1:0] ent;
    // on the boundary cycle slot 0 already uses the freshly committed map
    assign ent = commit ? pendMem[o][curSlot] : activeMem[o][curSlot];
    assign lkValid[o]                   = ent[ENT_W-1];
    assign lkLink[o*LINK_W +: LINK_W]   = ent[SLOT_W +: LINK_W];
    assign lkSlot[o*SLOT_W +: SLOT_W]   = ent[SLOT_W-1:0];
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_flat
      assign activeTbl[(o*NUM_SLOTS + k)*ENT_W +: ENT_W] = activeMem[o][k];
    end
  end
endmodule

// File: rtl/tsi_datapath.sv
`timescale 1ns/1ps
module tsi_datapath #(
  parameter int NUM_LINKS = 2,
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 8,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tsi_pkg::tsi_strobe_t          strobe,
  input  logic [SLOT_W-1:0]             curSlot,
  input  logic                          frameStart,
  input  logic [NUM_LINKS*DATA_W-1:0]   inData,
  input  logic [NUM_LINKS-1:0]          lkValid,
  input  logic [NUM_LINKS*LINK_W-1:0]   lkLink,
  input  logic [NUM_LINKS*SLOT_W-1:0]   lkSlot,
  output logic [NUM_LINKS*DATA_W-1:0]   outData,
  output logic                          outFrameStart
);
  logic [DATA_W-1:0] bankMem [2][NUM_LINKS][NUM_SLOTS];
  logic [DATA_W-1:0] pick    [NUM_LINKS];
  logic [DATA_W-1:0] outReg  [NUM_LINKS];
  logic rdBank;
  logic fsReg;

  assign rdBank = ~strobe.wrBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < NUM_LINKS; l++)
          for (int k = 0; k < NUM_SLOTS; k++)
            bankMem[b][l][k] <= '1;
    end else if (strobe.wrEn) begin
      for (int l = 0; l < NUM_LINKS; l++)
        bankMem[strobe.wrBank][l][curSlot] <= inData[l*DATA_W +: DATA_W];
    end
  end

  for (genvar o = 0; o < NUM_LINKS; o++) begin : g_rd
    assign pick[o] = lkValid[o]
                   ? bankMem[rdBank][lkLink[o*LINK_W +: LINK_W]][lkSlot[o*SLOT_W +: SLOT_W]]
                   : '1;
    assign outData[o*DATA_W +: DATA_W] = outReg[o];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int o = 0; o < NUM_LINKS; o++) outReg[o] <= '1;
      fsReg <= 1'b0;
    end else begin
      for (int o = 0; o < NUM_LINKS; o++) outReg[o] <= pick[o];
      fsReg <= frameStart;
    end
  end

  assign outFrameStart = fsReg;
endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch #(
  parameter int NUM_LINKS = 2,
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 8,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ENT_W  = 1 + LINK_W + SLOT_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameStart,
  input  logic [NUM_LINKS*DATA_W-1:0] inData,
  input  logic                        cfgWe,
  input  logic [LINK_W-1:0]           cfgOutLink,
  input  logic [SLOT_W-1:0]           cfgOutSlot,
  input  logic                        cfgValid,
  input  logic [LINK_W-1:0]           cfgSrcLink,
  input  logic [SLOT_W-1:0]           cfgSrcSlot,
  output logic [NUM_LINKS*DATA_W-1:0] outData,
  output logic                        outFrameStart
);
  tsi_pkg::tsi_strobe_t strobe;
  logic                            commit;
  logic [SLOT_W-1:0]               curSlot;
  logic [NUM_LINKS-1:0]            lkValid;
  logic [NUM_LINKS*LINK_W-1:0]     lkLink;
  logic [NUM_LINKS*SLOT_W-1:0]     lkSlot;
  logic [NUM_LINKS*NUM_SLOTS*ENT_W-1:0] activeTbl;

  tsi_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .strobe(strobe), .commit(commit), .curSlot(curSlot)
  );

  tsi_conn_table #(.NUM_LINKS(NUM_LINKS), .NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk(clk), .rstN(rstN), .commit(commit), .curSlot(curSlot),
    .cfgWe(cfgWe), .cfgOutLink(cfgOutLink), .cfgOutSlot(cfgOutSlot),
    .cfgValid(cfgValid), .cfgSrcLink(cfgSrcLink), .cfgSrcSlot(cfgSrcSlot),
    .lkValid(lkValid), .lkLink(lkLink), .lkSlot(lkSlot), .activeTbl(activeTbl)
  );

  tsi_datapath #(.NUM_LINKS(NUM_LINKS), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curSlot(curSlot),
    .frameStart(frameStart), .inData(inData),
    .lkValid(lkValid), .lkLink(lkLink), .lkSlot(lkSlot),
    .outData(outData), .outFrameStart(outFrameStart)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
`timescale 1ns/1ps
module tsi_switch_chk #(
  parameter int NUM_LINKS = 2,
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 8,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ENT_W  = 1 + LINK_W + SLOT_W
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 frameStart,
  input logic                                 outFrameStart,
  input logic [NUM_LINKS*DATA_W-1:0]          outData,
  input logic [NUM_LINKS-1:0]                 lkValid,
  input logic [NUM_LINKS*NUM_SLOTS*ENT_W-1:0] activeTbl
);
  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      idle_in_reset_chk: assert (outData == '1 && !outFrameStart);
    end
  end

  // R2
  fs_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> outFrameStart);

  // R2
  fs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> !outFrameStart);

  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeTbl));

  for (genvar o = 0; o < NUM_LINKS; o++) begin : g_lane
    // R4
    idle_on_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
      !lkValid[o] |=> outData[o*DATA_W +: DATA_W] == '1);
  end
endmodule

bind tsi_switch tsi_switch_chk #(
  .NUM_LINKS(NUM_LINKS), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .outFrameStart(outFrameStart),
  .outData(outData), .lkValid(lkValid), .activeTbl(activeTbl)
);

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
module tb_tsi_switch;
  localparam int N  = 2;
  localparam int S  = 8;
  localparam int DW = 8;
  localparam int LW = (N > 1) ? $clog2(N) : 1;
  localparam int SW = (S > 1) ? $clog2(S) : 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rstN;
  logic            frameStart;
  logic [N*DW-1:0] inData;
  logic            cfgWe;
  logic [LW-1:0]   cfgOutLink;
  logic [SW-1:0]   cfgOutSlot;
  logic            cfgValid;
  logic [LW-1:0]   cfgSrcLink;
  logic [SW-1:0]   cfgSrcSlot;
  logic [N*DW-1:0] outData;
  logic            outFrameStart;

  tsi_switch #(.NUM_LINKS(N), .NUM_SLOTS(S), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .inData(inData),
    .cfgWe(cfgWe), .cfgOutLink(cfgOutLink), .cfgOutSlot(cfgOutSlot),
    .cfgValid(cfgValid), .cfgSrcLink(cfgSrcLink), .cfgSrcSlot(cfgSrcSlot),
    .outData(outData), .outFrameStart(outFrameStart)
  );

  int checks = 0;
  int fails  = 0;
  string tag = "R3";

  typedef struct { int ol; int os; bit v; int sl; int ss; } wr_t;
  wr_t wq[$];

  // reference maps: pending and active
  bit pV[N][S]; int pL[N][S]; int pS[N][S];
  bit aV[N][S]; int aL[N][S]; int aS[N][S];

  function automatic logic [7:0] dataFn(int f, int l, int k);
    return 8'(f*29 + l*71 + k*13 + 1);
  endfunction

  function automatic void put(int ol, int os, bit v, int sl, int ss);
    wr_t w;
    w.ol = ol; w.os = os; w.v = v; w.sl = sl; w.ss = ss;
    wq.push_back(w);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one slot cycle; frame < 0 means no frame running yet
  task automatic slotCycle(int frame, int slot);
    bit fs;
    fs = (frame >= 0) && (slot == 0);
    frameStart = fs;
    for (int l = 0; l < N; l++)
      inData[l*DW +: DW] = (frame >= 0) ? dataFn(frame, l, slot) : 8'h00;
    if (fs) begin
      aV = pV; aL = pL; aS = pS;
    end
    if (wq.size() > 0) begin
      wr_t w;
      w = wq.pop_front();
      cfgWe = 1'b1;
      cfgOutLink = LW'(w.ol); cfgOutSlot = SW'(w.os);
      cfgValid = w.v; cfgSrcLink = LW'(w.sl); cfgSrcSlot = SW'(w.ss);
      pV[w.ol][w.os] = w.v; pL[w.ol][w.os] = w.sl; pS[w.ol][w.os] = w.ss;
    end else begin
      cfgWe = 1'b0;
    end
    @(posedge clk);
    #1;
    for (int o = 0; o < N; o++) begin
      logic [7:0] exp;
      string rq;
      if (frame <= 0) begin
        exp = 8'hFF; rq = "R7";
      end else if (!aV[o][slot]) begin
        exp = 8'hFF; rq = "R4";
      end else begin
        exp = dataFn(frame - 1, aL[o][slot], aS[o][slot]); rq = tag;
      end
      check(rq, $sformatf("lane%0d frame%0d slot%0d", o, frame, slot),
            32'(outData[o*DW +: DW]), 32'(exp));
    end
    check("R2", $sformatf("outFrameStart frame%0d slot%0d", frame, slot),
          32'(outFrameStart), 32'(fs));
  endtask

  task automatic runFrame(int frame);
    for (int k = 0; k < S; k++) slotCycle(frame, k);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int fr;
    rstN = 1'b0; frameStart = 1'b0; inData = '0; cfgWe = 1'b0;
    cfgOutLink = '0; cfgOutSlot = '0; cfgValid = 1'b0; cfgSrcLink = '0; cfgSrcSlot = '0;
    for (int o = 0; o < N; o++)
      for (int k = 0; k < S; k++) begin
        pV[o][k] = 0; pL[o][k] = 0; pS[o][k] = 0;
      end
    aV = pV; aL = pL; aS = pS;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state at the ports
    check("R1", "outData in reset", 32'(outData), 32'({N*DW{1'b1}}));
    check("R1", "outFrameStart in reset", 32'(outFrameStart), 32'd0);
    rstN = 1'b1;

    // R7/R8: load a reversing map with one idle entry before any frame
    for (int o = 0; o < N; o++)
      for (int k = 0; k < S; k++)
        put(o, k, !(o == 1 && k == 3), (o + 1) % N, S - 1 - k);
    for (int i = 0; i < N*S + 2; i++) slotCycle(-1, 0);

    fr = 0;
    tag = "R3";
    for (int i = 0; i < 3; i++) begin runFrame(fr); fr++; end

    // R5: mid-frame writes must not touch the frame in progress
    tag = "R5";
    for (int k = 0; k < S; k++) begin
      if (k == 4) begin
        put(0, 0, 1'b1, 0, 5);
        put(0, 6, 1'b1, 1, 2);
      end
      slotCycle(fr, k);
    end
    fr++;
    runFrame(fr); fr++;
    // R5: write coinciding with the frame pulse waits one more frame
    put(1, 1, 1'b1, 0, 0);
    runFrame(fr); fr++;
    runFrame(fr); fr++;

    // R6: one source slot fans out to many output slots on both links
    tag = "R6";
    for (int k = 0; k < S/2; k++) put(0, k, 1'b1, 0, 2);
    for (int k = S/2; k < S; k++) put(1, k, 1'b1, 0, 2);
    for (int i = 0; i < 3; i++) begin runFrame(fr); fr++; end

    // R4: idle out some entries
    tag = "R3";
    for (int k = 0; k < S; k += 2) put(0, k, 1'b0, 1, k);
    for (int i = 0; i < 2; i++) begin runFrame(fr); fr++; end

    // R8: sweep every entry through rotated maps
    tag = "R8";
    for (int r = 1; r <= 4; r++) begin
      for (int o = 0; o < N; o++)
        for (int k = 0; k < S; k++)
          put(o, k, 1'b1, (o + r) % N, (k*3 + r) % S);
      for (int i = 0; i < 3; i++) begin runFrame(fr); fr++; end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule